// File: doc/BRIEF.md
# Clock Control Status Register

This block is the 32-bit control and status word of a microcontroller clock unit. It sits on a simple register bus at offset 0. Software uses it to switch on an internal RC oscillator and set that oscillator's trim, to switch on an external crystal oscillator or put it in bypass, to start a main PLL and an auxiliary audio PLL, and to arm a clock security monitor. Hardware fills in the read-only part of the word: the oscillator-stable and PLL-lock inputs appear as ready flags, and a factory calibration code is reflected live. Writes are sorted by byte lane. A read returns the word combinationally in the same cycle as the access, with no wait states.

Hardware has authority over software in three cases. A pulse on the low-power entry input clears both PLL enables. The main PLL enable cannot be cleared while the system clock runs from that PLL. The clock-failure detector enable output is driven by a small state machine with four states, named as follows:
- DET_IDLE: the security enable is off.
- DET_ARMED: the security enable is on and the crystal is not yet ready.
- DET_LIVE: the detector runs.
- DET_TRIPPED: a failure was seen.

The state machine has these transitions:
- IDLE→LIVE when the enable is set and the crystal is ready.
- IDLE→ARMED when the enable is set and the crystal is not ready.
- ARMED→LIVE when the crystal becomes ready and no failure is present.
- LIVE→ARMED when ready drops.
- LIVE→TRIPPED when a failure is flagged.
- Any state except IDLE goes back to IDLE when software clears the enable.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset the RC enable (bit 0) is 1, the trim field (bits 7:3) is 0x10, and every other writable bit is 0. With the RC-stable input low, the low byte reads 0x81.
- R2: A write at offset 0 updates only the byte lanes whose strobe bit is set (strobe bit n covers data bits 8n+7:8n). The other lanes keep their value.
- R3: Bits 2, 23:20 and 31:28 always read 0, and writing them has no effect.
- R4: The ready flags are live copies of their inputs: RC at bit 1, crystal at bit 17, main PLL lock at bit 25, auxiliary PLL lock at bit 27. Bits 15:8 are a live copy of the calibration input. Writes to these bits have no effect.
- R5: Read data is the register word in the same cycle as a read at offset 0. It is 0 when there is no read or when the address does not match.
- R6: A low-power entry pulse clears the main PLL enable (bit 24) and the auxiliary PLL enable (bit 26) at the next clock edge. This clear wins over a write in the same cycle and over the system-clock hold.
- R7: A write of 0 to bit 24 is ignored while the system-clock-is-PLL input is high. Otherwise the write takes effect.
- R8: The detector enable output is high only in DET_LIVE, with the security enable (bit 19) set, the crystal ready, and no failure input. A failure input forces the output low in the same cycle.
- R9: After a failure in DET_LIVE, the detector output stays low even when ready returns. It comes back only after software clears bit 19 and sets it again.
- R10: The outputs rc_en_o, trim_o, xtal_en_o, xtal_bypass_o, main_pll_en_o and aux_pll_en_o follow bits 0, 7:3, 16, 18, 24 and 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Read data, combinational |
| rc_stable_i | input | 1 | RC oscillator stable |
| xtal_stable_i | input | 1 | Crystal oscillator stable |
| main_lock_i | input | 1 | Main PLL locked |
| aux_lock_i | input | 1 | Auxiliary PLL locked |
| cal_code_i | input | 8 | Calibration code |
| lowpwr_entry_i | input | 1 | Low-power mode entry pulse |
| sysclk_is_pll_i | input | 1 | System clock is the main PLL |
| clk_fail_i | input | 1 | Crystal failure flagged |
| rc_en_o | output | 1 | RC oscillator enable |
| trim_o | output | 5 | RC trim value |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| xtal_bypass_o | output | 1 | Crystal bypass |
| main_pll_en_o | output | 1 | Main PLL enable |
| aux_pll_en_o | output | 1 | Auxiliary PLL enable |
| det_en_o | output | 1 | Clock failure detector enable |

## Verification
The register word is tested with three access patterns:
- A full-word write of all ones shows that reserved and read-only bits cannot be set.
- A single-lane write and a half-word write of zeros show that strobes leave the unselected lanes alone.
- A swap of the live inputs separates stored bits from reflected bits.

The PLL enables are tested with three patterns, which tell the three hardware overrides apart:
- a low-power pulse on its own;
- a low-power pulse that coincides with a write;
- a write of zero while the system clock runs from the PLL, once with and once without a pulse.

The detector is walked through its states in order: armed, live, failure, failure released, and re-arm by toggling the enable. This shows that a failure latches until the enable is cycled.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int NUM_PLL  = 2;

    localparam int RC_EN    = 0;
    localparam int RC_RDY   = 1;
    localparam int TRIM_LO  = 3;
    localparam int TRIM_W   = 5;
    localparam int CAL_LO   = 8;
    localparam int CAL_W    = 8;
    localparam int XT_EN    = 16;
    localparam int XT_RDY   = 17;
    localparam int XT_BYP   = 18;
    localparam int SEC_EN   = 19;
    localparam int PLL_BASE = 24;

    localparam logic [DATA_W-1:0] RSVD_MASK = 32'hF0F0_0004;

    typedef enum logic [1:0] {
        DET_IDLE,
        DET_ARMED,
        DET_LIVE,
        DET_TRIPPED
    } det_state_e;

    function automatic int pll_en_bit(input int idx);
        return PLL_BASE + 2 * idx;
    endfunction

    function automatic int pll_rdy_bit(input int idx);
        return PLL_BASE + 2 * idx + 1;
    endfunction
endpackage

// File: rtl/ccr_bus_dec.sv
module ccr_bus_dec
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] OFFSET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  strb,
    output logic [LANES-1:0]  lane_we,
    output logic              rd_hit
);
    logic hit;

    always_comb begin
        hit     = sel && (addr == OFFSET);
        rd_hit  = hit && !wr;
        lane_we = (hit && wr) ? strb : '0;
    end

    assert_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we & ~strb) == '0);
    assert_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |-> lane_we == '0);
endmodule

// File: rtl/ccr_pll_bit.sv
module ccr_pll_bit #(
    parameter bit LOCKABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wbit_i,
    input  logic lowpwr_i,
    input  logic hold_i,
    output logic en_o
);
    logic blocked;

    always_comb begin
        blocked = LOCKABLE && hold_i && !wbit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= 1'b0;
        end else if (lowpwr_i) begin
            en_o <= 1'b0;
        end else if (we_i && !blocked) begin
            en_o <= wbit_i;
        end
    end

    assert_lp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_i |=> !en_o);

    generate
        if (LOCKABLE) begin : g_hold_chk
            assert_pll_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_i && en_o && !lowpwr_i) |=> en_o);
        end
    endgenerate
endmodule

// File: rtl/ccr_guard_fsm.sv
module ccr_guard_fsm
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_en_i,
    input  logic osc_rdy_i,
    input  logic fail_i,
    output logic det_en_o
);
    det_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            DET_IDLE: begin
                if (sec_en_i) nxt = osc_rdy_i ? DET_LIVE : DET_ARMED;
            end
            DET_ARMED: begin
                if (!sec_en_i)                nxt = DET_IDLE;
                else if (osc_rdy_i && !fail_i) nxt = DET_LIVE;
            end
            DET_LIVE: begin
                if (!sec_en_i)      nxt = DET_IDLE;
                else if (fail_i)    nxt = DET_TRIPPED;
                else if (!osc_rdy_i) nxt = DET_ARMED;
            end
            DET_TRIPPED: begin
                if (!sec_en_i) nxt = DET_IDLE;
            end
            default: nxt = DET_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DET_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        det_en_o = (state == DET_LIVE) && sec_en_i && osc_rdy_i && !fail_i;
    end

    assert_det_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        det_en_o |-> (sec_en_i && osc_rdy_i && !fail_i));
    assert_trip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_TRIPPED && sec_en_i) |=> !det_en_o);
    assert_trip_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_LIVE && sec_en_i && fail_i) |=> (state == DET_TRIPPED || !sec_en_i));
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_OFFSET = '0,
    parameter logic [TRIM_W-1:0] TRIM_RST = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [LANES-1:0]  bus_strb,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rc_stable_i,
    input  logic              xtal_stable_i,
    input  logic              main_lock_i,
    input  logic              aux_lock_i,
    input  logic [CAL_W-1:0]  cal_code_i,
    input  logic              lowpwr_entry_i,
    input  logic              sysclk_is_pll_i,
    input  logic              clk_fail_i,
    output logic              rc_en_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic              xtal_en_o,
    output logic              xtal_bypass_o,
    output logic              main_pll_en_o,
    output logic              aux_pll_en_o,
    output logic              det_en_o
);
    localparam int TRIM_LANE = TRIM_LO / 8;
    localparam int XT_LANE   = XT_EN / 8;

    logic [LANES-1:0]   lane_we;
    logic               rd_hit;
    logic               rc_en_q, xt_en_q, xt_byp_q, sec_en_q;
    logic [TRIM_W-1:0]  trim_q;
    logic [NUM_PLL-1:0] pll_en, pll_lock;
    logic [DATA_W-1:0]  word;

    assign pll_lock = {aux_lock_i, main_lock_i};

    ccr_bus_dec #(.ADDR_W(ADDR_W), .OFFSET(REG_OFFSET)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .strb    (bus_strb),
        .lane_we (lane_we),
        .rd_hit  (rd_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_en_q  <= 1'b1;
            trim_q   <= TRIM_RST;
            xt_en_q  <= 1'b0;
            xt_byp_q <= 1'b0;
            sec_en_q <= 1'b0;
        end else begin
            if (lane_we[TRIM_LANE]) begin
                rc_en_q <= bus_wdata[RC_EN];
                trim_q  <= bus_wdata[TRIM_LO +: TRIM_W];
            end
            if (lane_we[XT_LANE]) begin
                xt_en_q  <= bus_wdata[XT_EN];
                xt_byp_q <= bus_wdata[XT_BYP];
                sec_en_q <= bus_wdata[SEC_EN];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
            localparam int EB = pll_en_bit(g);
            ccr_pll_bit #(.LOCKABLE(g == 0)) u_pll (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_i     (lane_we[EB / 8]),
                .wbit_i   (bus_wdata[EB]),
                .lowpwr_i (lowpwr_entry_i),
                .hold_i   (sysclk_is_pll_i),
                .en_o     (pll_en[g])
            );
        end
    endgenerate

    ccr_guard_fsm u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_en_i  (sec_en_q),
        .osc_rdy_i (xtal_stable_i),
        .fail_i    (clk_fail_i),
        .det_en_o  (det_en_o)
    );

    always_comb begin
        word = '0;
        word[RC_EN]              = rc_en_q;
        word[RC_RDY]             = rc_stable_i;
        word[TRIM_LO +: TRIM_W]  = trim_q;
        word[CAL_LO +: CAL_W]    = cal_code_i;
        word[XT_EN]              = xt_en_q;
        word[XT_RDY]             = xtal_stable_i;
        word[XT_BYP]             = xt_byp_q;
        word[SEC_EN]             = sec_en_q;
        for (int i = 0; i < NUM_PLL; i++) begin
            word[pll_en_bit(i)]  = pll_en[i];
            word[pll_rdy_bit(i)] = pll_lock[i];
        end
        bus_rdata = rd_hit ? word : '0;
    end

    assign rc_en_o       = rc_en_q;
    assign trim_o        = trim_q;
    assign xtal_en_o     = xt_en_q;
    assign xtal_bypass_o = xt_byp_q;
    assign main_pll_en_o = pll_en[0];
    assign aux_pll_en_o  = pll_en[1];

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[31:27], bus_wdata[25], bus_wdata[23:20],
                            bus_wdata[17], bus_wdata[15:8], bus_wdata[2:1]};

    assert_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (bus_rdata & RSVD_MASK) == '0);
    assert_cal_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> bus_rdata[CAL_LO +: CAL_W] == cal_code_i);
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> bus_rdata == '0);
    assert_lane0_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we[TRIM_LANE] |=> $stable(trim_o));
endmodule

// File: tb/tb_clk_ctrl_reg.sv
`timescale 1ns/1ps
module tb_clk_ctrl_reg;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic rc_stable_i = 0, xtal_stable_i = 0, main_lock_i = 0, aux_lock_i = 0;
    logic [7:0] cal_code_i = 8'h5A;
    logic lowpwr_entry_i = 0, sysclk_is_pll_i = 0, clk_fail_i = 0;
    logic rc_en_o, xtal_en_o, xtal_bypass_o, main_pll_en_o, aux_pll_en_o, det_en_o;
    logic [4:0] trim_o;

    always #4 clk = ~clk;

    clk_ctrl_reg #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_rdata(bus_rdata), .rc_stable_i(rc_stable_i),
        .xtal_stable_i(xtal_stable_i), .main_lock_i(main_lock_i),
        .aux_lock_i(aux_lock_i), .cal_code_i(cal_code_i),
        .lowpwr_entry_i(lowpwr_entry_i), .sysclk_is_pll_i(sysclk_is_pll_i),
        .clk_fail_i(clk_fail_i), .rc_en_o(rc_en_o), .trim_o(trim_o),
        .xtal_en_o(xtal_en_o), .xtal_bypass_o(xtal_bypass_o),
        .main_pll_en_o(main_pll_en_o), .aux_pll_en_o(aux_pll_en_o),
        .det_en_o(det_en_o)
    );

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int applied = 0;
    int fails = 0;
    bit done = 0;

    wire [10:0] outvec = {det_en_o, aux_pll_en_o, main_pll_en_o, xtal_bypass_o,
                          xtal_en_o, trim_o, rc_en_o};

    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] obs;
                it  = q.pop_front();
                obs = (it.kind == 0) ? bus_rdata : {21'b0, outvec};
                applied++;
                if (obs !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.req, obs, it.exp);
                end
            end
        end
    end

    task automatic push(input string req, input int kind, input logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] s, input bit lp);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = '0; bus_wdata = d; bus_strb = s;
        lowpwr_entry_i = lp;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_strb = '0; lowpwr_entry_i = 0;
    endtask

    task automatic chk_rd(input string req, input logic [AW-1:0] a, input bit en,
                          input logic [31:0] exp);
        bus_sel = en; bus_wr = 0; bus_addr = a;
        push(req, 0, exp);
        @(negedge clk);
        bus_sel = 0; bus_addr = '0;
    endtask

    task automatic chk_out(input string req, input logic [10:0] exp);
        push(req, 1, {21'b0, exp});
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk_rd("R1 reset word", '0, 1, 32'h0000_5A81);
        chk_out("R1 reset outputs", 11'h021);
        // R3 R4 full write cannot touch reserved or read-only bits
        wr(32'hFFFF_FFFF, 4'hF, 0);
        chk_rd("R3 R4 full write", '0, 1, 32'h050D_5AF9);
        chk_out("R10 outputs follow fields", 11'h3FF);
        // R2 lane strobes
        wr(32'h0, 4'b0001, 0);
        chk_rd("R2 byte lane", '0, 1, 32'h050D_5A00);
        wr(32'h0, 4'b1100, 0);
        chk_rd("R2 halfword lanes", '0, 1, 32'h0000_5A00);
        // R4 live flags and calibration
        rc_stable_i = 1; xtal_stable_i = 1; main_lock_i = 1; aux_lock_i = 1;
        cal_code_i = 8'hC3;
        chk_rd("R4 live flags", '0, 1, 32'h0A02_C302);
        rc_stable_i = 0; xtal_stable_i = 0; main_lock_i = 0; aux_lock_i = 0;
        // R5 no read / wrong address
        chk_rd("R5 idle read zero", '0, 0, 32'h0);
        chk_rd("R5 address miss", 4'h4, 1, 32'h0);
        // R6 low-power clear
        wr(32'h0500_0000, 4'b1000, 0);
        chk_rd("R6 plls on", '0, 1, 32'h0500_C300);
        @(negedge clk); lowpwr_entry_i = 1;
        @(negedge clk); lowpwr_entry_i = 0;
        chk_rd("R6 lowpwr clears", '0, 1, 32'h0000_C300);
        wr(32'h0500_0000, 4'b1000, 1);
        chk_rd("R6 lowpwr beats write", '0, 1, 32'h0000_C300);
        // R7 main enable hold
        wr(32'h0500_0000, 4'b1000, 0);
        sysclk_is_pll_i = 1;
        wr(32'h0, 4'b1000, 0);
        chk_rd("R7 main held aux cleared", '0, 1, 32'h0100_C300);
        wr(32'h0, 4'b1000, 1);
        chk_rd("R6 lowpwr beats hold", '0, 1, 32'h0000_C300);
        sysclk_is_pll_i = 0;
        wr(32'h0100_0000, 4'b1000, 0);
        wr(32'h0, 4'b1000, 0);
        chk_rd("R7 clear when not sysclk", '0, 1, 32'h0000_C300);
        // R8 R9 detector
        wr(32'h0008_0000, 4'b0100, 0);
        @(negedge clk);
        chk_out("R8 armed no ready", 11'h000);
        xtal_stable_i = 1;
        @(negedge clk);
        chk_out("R8 live", 11'h400);
        clk_fail_i = 1;
        chk_out("R8 fail forces off", 11'h000);
        clk_fail_i = 0;
        @(negedge clk);
        chk_out("R9 tripped stays off", 11'h000);
        chk_rd("R9 enable still set", '0, 1, 32'h000A_C300);
        wr(32'h0, 4'b0100, 0);
        wr(32'h0008_0000, 4'b0100, 0);
        @(negedge clk);
        chk_out("R9 rearm", 11'h400);
        repeat (2) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule